// File: doc/BRIEF.md
# CAN Node Fault-Mode Supervisor

This block is a supervisory state machine placed between a CAN protocol controller and its line transceiver. It watches the controller's transmit and receive error counters, the bus-off indication, the raw receive level sampled once per bit time, and the transceiver's undervoltage and overtemperature flags. From that evidence it decides whether the node may transmit freely, must transmit at a reduced duty, may only listen, or must keep its driver off the bus.

The node degrades before it reaches bus-off, drops its driver when the line is held dominant, and holds listen-only while the transceiver rail is low. After bus-off or a lasting overtemperature, it rejoins only once the bus has been quiet for a window that doubles after every rejoin. After a fixed number of rejoins it locks out until the host clears it. Every change of mode produces a one-cycle event strobe, the new mode code and a cycle stamp, so a logger can record the history.

Top module: `can_fault_supervisor`

## Requirements
- R1: After reset the mode code is 0 (normal). `tx_en` is 1. `tx_throttle`, `listen_only`, `stuck_fault`, `locked_out` and `evt_stb` are 0.
- R2: When `tec` or `rec` is strictly greater than `cfg_warn`, a normal node moves to mode 1 (degraded) and raises `tx_throttle`. While throttled, `tx_en` is high on exactly one cycle in every `DUTY_PERIOD`. A count equal to `cfg_warn` keeps mode 0.
- R3: `bus_off` in mode 0, 1 or 2 moves the node to mode 3 (isolated), and `tx_en` goes low.
- R4: The node leaves mode 3 for mode 0 only after the bus has been idle for a quiet window of cycles. Idle means the last 11 bit samples were all recessive. Any dominant sample restarts the window. The window is `QUIET_BASE` doubled once per rejoin already made, capped at `QUIET_MAX`, so a later isolation lasts longer than an earlier one.
- R5: A bus-off or overtemperature trip after `RETRY_CAP` rejoins leads to mode 5 (locked) with `locked_out` high instead of mode 3. Mode 5 is left only by `host_clear`, which also resets the rejoin count. `host_clear` has no effect in any other mode.
- R6: More than `cfg_stuck_bits` consecutive dominant bit samples put the node in mode 4 (stuck), with `stuck_fault` high and `tx_en` low. The node returns to mode 0 once the bus is idle.
- R7: While `xcvr_uv` is high, a node in mode 0 or 1 moves to mode 2 (listen-only) with `listen_only` high and `tx_en` low. It leaves only after `xcvr_uv` has been low for `cfg_uv_hold` consecutive cycles.
- R8: While `xcvr_ot` is high in mode 0 or 1, `tx_throttle` is high and the duty limit of R2 applies. When `xcvr_ot` stays high for `OT_LIMIT` cycles, the node moves to mode 3, or to mode 5 under R5.
- R9: On each mode change, `evt_stb` pulses for one cycle together with the new `state_code`. `evt_time` then holds the number of clock cycles from reset release to the edge that made the change.
- R10: When several conditions hold at once, they take effect in this order: stuck bus first, then bus-off or overtemperature trip, then undervoltage, then the warning threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| bus_rx | input | 1 | Raw receive level, 1 = recessive |
| tec | input | CNT_W | Transmit error counter |
| rec | input | CNT_W | Receive error counter |
| bus_off | input | 1 | Controller bus-off indication |
| xcvr_uv | input | 1 | Transceiver undervoltage flag |
| xcvr_ot | input | 1 | Transceiver overtemperature flag |
| host_clear | input | 1 | Host release of the locked mode |
| cfg_warn | input | CNT_W | Error-counter warning threshold |
| cfg_stuck_bits | input | STUCK_W | Longest dominant run accepted, in bits |
| cfg_uv_hold | input | HOLD_W | Cycles the rail must stay good |
| tx_en | output | 1 | Transmit driver enable |
| listen_only | output | 1 | Controller listen-only request |
| tx_throttle | output | 1 | Transmit rate is limited |
| stuck_fault | output | 1 | Dominant-stuck fault reported |
| locked_out | output | 1 | Retry cap reached, host action needed |
| state_code | output | 3 | Current mode code |
| evt_stb | output | 1 | Mode-change strobe |
| evt_time | output | TS_W | Cycle stamp of the last mode change |

## Verification
The bench builds the block with a quiet base of 8 cycles, a cap of 20 and a retry limit of 2. With these values one bus-off held high runs the whole backoff ladder into lockout in well under a hundred cycles, and two dwell lengths can be compared. The overtemperature limit is set to 30 cycles and the duty period to 4, so both the throttle pattern and the overtemperature trip are reached quickly. The bit strobe fires every other cycle. This makes the 11-bit idle rule and a stuck limit of 5 bits visible in tens of cycles, and shows the quiet window restarting after a dominant glitch.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE   = 3'd0,
    ST_DEGRADED = 3'd1,
    ST_LISTEN   = 3'd2,
    ST_ISOLATED = 3'd3,
    ST_STUCK    = 3'd4,
    ST_LOCKED   = 3'd5
  } cfs_state_e;
endpackage

// File: rtl/cfs_persist.sv
module cfs_persist #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cond,
  input  logic [W-1:0] limit,
  output logic         reached
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (!cond)     cnt_q <= '0;
    else if (cnt_q < limit) cnt_q <= cnt_q + 1'b1;
  end

  assign reached = cond && (cnt_q >= limit);

  a_persist_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt_q <= limit) || $changed(limit))
    else $error("persistence counter ran past its limit");
endmodule

// File: rtl/cfs_line_watch.sv
module cfs_line_watch #(
  parameter int STUCK_W   = 8,
  parameter int IDLE_BITS = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_tick,
  input  logic               bus_rx,
  input  logic [STUCK_W-1:0] cfg_stuck_bits,
  output logic               stuck,
  output logic               idle
);
  localparam int DOM_W = STUCK_W + 1;
  localparam int REC_W = $clog2(IDLE_BITS + 1);
  localparam logic [DOM_W-1:0] DOM_MAX = '1;
  localparam logic [REC_W-1:0] REC_MAX = REC_W'(IDLE_BITS);

  logic [DOM_W-1:0] dom_q;
  logic [REC_W-1:0] rec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dom_q <= '0;
      rec_q <= '0;
    end else if (bit_tick) begin
      if (!bus_rx) begin
        dom_q <= (dom_q == DOM_MAX) ? dom_q : dom_q + 1'b1;
        rec_q <= '0;
      end else begin
        rec_q <= (rec_q == REC_MAX) ? rec_q : rec_q + 1'b1;
        dom_q <= '0;
      end
    end
  end

  assign stuck = dom_q > {1'b0, cfg_stuck_bits};
  assign idle  = rec_q >= REC_MAX;

  a_idle_excl_stuck_R6: assert property (@(posedge clk) disable iff (rst)
    !(idle && (dom_q != '0)))
    else $error("idle and dominant run reported together");
endmodule

// File: rtl/cfs_quiet_backoff.sv
module cfs_quiet_backoff #(
  parameter int QUIET_BASE = 64,
  parameter int QUIET_MAX  = 256,
  parameter int RETRY_CAP  = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 run,
  input  logic                                 rejoin,
  input  logic                                 clear,
  output logic                                 done,
  output logic [$clog2(RETRY_CAP+1)-1:0]       attempts,
  output logic                                 at_cap
);
  localparam int Q_W   = $clog2(QUIET_MAX + 1);
  localparam int ATT_W = $clog2(RETRY_CAP + 1);
  localparam logic [Q_W-1:0]   Q_SAT   = Q_W'(QUIET_MAX);
  localparam logic [ATT_W-1:0] ATT_CAP = ATT_W'(RETRY_CAP);

  logic [Q_W-1:0]   q_q;
  logic [ATT_W-1:0] att_q;
  logic [31:0]      win;

  always_comb begin
    win = 32'(QUIET_BASE) << att_q;
    if (win > 32'(QUIET_MAX)) win = 32'(QUIET_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst)       q_q <= '0;
    else if (run)  q_q <= (q_q == Q_SAT) ? q_q : q_q + 1'b1;
    else           q_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)                    att_q <= '0;
    else if (rejoin && (att_q < ATT_CAP)) att_q <= att_q + 1'b1;
  end

  assign done     = run && (32'(q_q) >= win);
  assign attempts = att_q;
  assign at_cap   = (att_q == ATT_CAP);

  a_attempt_cap_R5: assert property (@(posedge clk) disable iff (rst)
    att_q <= ATT_CAP)
    else $error("rejoin count beyond cap");
  a_window_restart_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (q_q == '0))
    else $error("quiet window not restarted");
endmodule

// File: rtl/can_fault_supervisor.sv
module can_fault_supervisor
  import cfs_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int STUCK_W     = 8,
  parameter int HOLD_W      = 12,
  parameter int OT_LIMIT    = 200,
  parameter int QUIET_BASE  = 64,
  parameter int QUIET_MAX   = 256,
  parameter int RETRY_CAP   = 3,
  parameter int DUTY_PERIOD = 4,
  parameter int TS_W        = 16,
  parameter int IDLE_BITS   = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_tick,
  input  logic               bus_rx,
  input  logic [CNT_W-1:0]   tec,
  input  logic [CNT_W-1:0]   rec,
  input  logic               bus_off,
  input  logic               xcvr_uv,
  input  logic               xcvr_ot,
  input  logic               host_clear,
  input  logic [CNT_W-1:0]   cfg_warn,
  input  logic [STUCK_W-1:0] cfg_stuck_bits,
  input  logic [HOLD_W-1:0]  cfg_uv_hold,
  output logic               tx_en,
  output logic               listen_only,
  output logic               tx_throttle,
  output logic               stuck_fault,
  output logic               locked_out,
  output logic [2:0]         state_code,
  output logic               evt_stb,
  output logic [TS_W-1:0]    evt_time
);
  localparam int OT_W   = $clog2(OT_LIMIT + 1);
  localparam int ATT_W  = $clog2(RETRY_CAP + 1);
  localparam int DUTY_W = (DUTY_PERIOD > 1) ? $clog2(DUTY_PERIOD) : 1;
  localparam logic [DUTY_W-1:0] DUTY_LAST = DUTY_W'(DUTY_PERIOD - 1);

  cfs_state_e        state_q, nx;
  logic              stuck, idle, uv_ok, ot_trip, quiet_done, at_cap;
  logic [ATT_W-1:0]  attempts;
  logic              warn, trip, run, rejoin, clear, may_tx, thr_n;
  logic [DUTY_W-1:0] duty_q;
  logic [TS_W-1:0]   ts_q;

  cfs_line_watch #(.STUCK_W(STUCK_W), .IDLE_BITS(IDLE_BITS)) u_line (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .bus_rx(bus_rx),
    .cfg_stuck_bits(cfg_stuck_bits), .stuck(stuck), .idle(idle));

  cfs_persist #(.W(HOLD_W)) u_uv_hold (
    .clk(clk), .rst(rst), .cond(!xcvr_uv), .limit(cfg_uv_hold), .reached(uv_ok));

  cfs_persist #(.W(OT_W)) u_ot_hold (
    .clk(clk), .rst(rst), .cond(xcvr_ot), .limit(OT_W'(OT_LIMIT)), .reached(ot_trip));

  cfs_quiet_backoff #(.QUIET_BASE(QUIET_BASE), .QUIET_MAX(QUIET_MAX),
                      .RETRY_CAP(RETRY_CAP)) u_quiet (
    .clk(clk), .rst(rst), .run(run), .rejoin(rejoin), .clear(clear),
    .done(quiet_done), .attempts(attempts), .at_cap(at_cap));

  assign warn   = (tec > cfg_warn) || (rec > cfg_warn);
  assign trip   = bus_off || ot_trip;
  assign run    = (state_q == ST_ISOLATED) && idle;
  assign rejoin = (state_q == ST_ISOLATED) && quiet_done;
  assign clear  = (state_q == ST_LOCKED) && host_clear;

  always_comb begin
    nx = state_q;
    unique case (state_q)
      ST_ACTIVE, ST_DEGRADED: begin
        if (stuck)        nx = ST_STUCK;
        else if (trip)    nx = at_cap ? ST_LOCKED : ST_ISOLATED;
        else if (xcvr_uv) nx = ST_LISTEN;
        else if (warn)    nx = ST_DEGRADED;
        else              nx = ST_ACTIVE;
      end
      ST_LISTEN: begin
        if (stuck)        nx = ST_STUCK;
        else if (trip)    nx = at_cap ? ST_LOCKED : ST_ISOLATED;
        else if (uv_ok)   nx = warn ? ST_DEGRADED : ST_ACTIVE;
      end
      ST_ISOLATED: if (quiet_done) nx = ST_ACTIVE;
      ST_STUCK:    if (idle)       nx = ST_ACTIVE;
      ST_LOCKED:   if (host_clear) nx = ST_ACTIVE;
      default:     nx = ST_ACTIVE;
    endcase
  end

  assign may_tx = (nx == ST_ACTIVE) || (nx == ST_DEGRADED);
  assign thr_n  = (nx == ST_DEGRADED) || (may_tx && xcvr_ot);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_ACTIVE;
      duty_q      <= '0;
      ts_q        <= '0;
      tx_en       <= 1'b1;
      listen_only <= 1'b0;
      tx_throttle <= 1'b0;
      stuck_fault <= 1'b0;
      locked_out  <= 1'b0;
      state_code  <= 3'd0;
      evt_stb     <= 1'b0;
      evt_time    <= '0;
    end else begin
      state_q     <= nx;
      duty_q      <= (duty_q == DUTY_LAST) ? '0 : duty_q + 1'b1;
      ts_q        <= ts_q + 1'b1;
      tx_en       <= may_tx && (!thr_n || (duty_q == '0));
      listen_only <= (nx == ST_LISTEN);
      tx_throttle <= thr_n;
      stuck_fault <= (nx == ST_STUCK);
      locked_out  <= (nx == ST_LOCKED);
      state_code  <= nx;
      evt_stb     <= (nx != state_q);
      if (nx != state_q) evt_time <= ts_q;
    end
  end

  a_busoff_isolates_R3: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_ACTIVE) && bus_off && !stuck) |=> !tx_en && (state_code >= 3'd3))
    else $error("bus-off did not isolate");
  a_quiet_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_ISOLATED) && !idle) |=> (state_code == 3'd3))
    else $error("left isolation without quiet bus");
  a_stuck_drops_tx_R6: assert property (@(posedge clk) disable iff (rst)
    (stuck && (state_q != ST_ISOLATED) && (state_q != ST_LOCKED)) |=> stuck_fault && !tx_en)
    else $error("stuck bus not acted on");
  a_uv_listen_R7: assert property (@(posedge clk) disable iff (rst)
    (xcvr_uv && ((state_q == ST_ACTIVE) || (state_q == ST_DEGRADED)) && !stuck && !trip)
      |=> listen_only && !tx_en)
    else $error("undervoltage did not force listen-only");
  a_evt_change_R9: assert property (@(posedge clk) disable iff (rst)
    evt_stb |-> (state_code != $past(state_code)))
    else $error("event strobe without mode change");

  generate
    if (DUTY_PERIOD > 1) begin : g_duty_chk
      a_duty_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_throttle && tx_en) |=> (!tx_en || !tx_throttle))
        else $error("throttled transmit on consecutive cycles");
    end
  endgenerate
endmodule

// File: tb/test_can_fault_supervisor.sv
`timescale 1ns/100ps
module test_can_fault_supervisor;
  localparam int CNT_W = 9, STUCK_W = 8, HOLD_W = 8;
  localparam int OT_LIM = 30, QB = 8, QM = 20, CAP = 2, DUTY = 4, TS_W = 16;

  logic clk = 0, rst = 1, bit_tick = 0, bus_rx = 1;
  logic [CNT_W-1:0] tec = 0, rec = 0, cfg_warn = 9'd96;
  logic bus_off = 0, xcvr_uv = 0, xcvr_ot = 0, host_clear = 0;
  logic [STUCK_W-1:0] cfg_stuck_bits = 8'd5;
  logic [HOLD_W-1:0] cfg_uv_hold = 8'd6;
  logic tx_en, listen_only, tx_throttle, stuck_fault, locked_out, evt_stb;
  logic [2:0] state_code;
  logic [TS_W-1:0] evt_time;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  can_fault_supervisor #(.CNT_W(CNT_W), .STUCK_W(STUCK_W), .HOLD_W(HOLD_W),
    .OT_LIMIT(OT_LIM), .QUIET_BASE(QB), .QUIET_MAX(QM), .RETRY_CAP(CAP),
    .DUTY_PERIOD(DUTY), .TS_W(TS_W), .IDLE_BITS(11)) i_can_fault_supervisor (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .bus_rx(bus_rx), .tec(tec), .rec(rec),
    .bus_off(bus_off), .xcvr_uv(xcvr_uv), .xcvr_ot(xcvr_ot), .host_clear(host_clear),
    .cfg_warn(cfg_warn), .cfg_stuck_bits(cfg_stuck_bits), .cfg_uv_hold(cfg_uv_hold),
    .tx_en(tx_en), .listen_only(listen_only), .tx_throttle(tx_throttle),
    .stuck_fault(stuck_fault), .locked_out(locked_out), .state_code(state_code),
    .evt_stb(evt_stb), .evt_time(evt_time));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: mode numbers 0 normal,1 degraded,2 listen,3 isolated,4 stuck,5 locked
  int m_state, m_dom, m_rec, m_uvc, m_otc, m_q, m_att, m_duty, m_ts;
  int m_tx, m_lo, m_thr, m_sf, m_lk, m_evt, m_etime;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_dom = 0; m_rec = 0; m_uvc = 0; m_otc = 0; m_q = 0; m_att = 0;
      m_duty = 0; m_ts = 0; m_tx = 1; m_lo = 0; m_thr = 0; m_sf = 0; m_lk = 0;
      m_evt = 0; m_etime = 0;
    end else begin
      bit stk, idl, uvok, ottr, run, done, warn, trip, mtx;
      int win, iso, nx;
      stk  = m_dom > cfg_stuck_bits;
      idl  = m_rec >= 11;
      uvok = !xcvr_uv && (m_uvc >= cfg_uv_hold);
      ottr = xcvr_ot && (m_otc >= OT_LIM);
      run  = (m_state == 3) && idl;
      win  = QB << m_att; if (win > QM) win = QM;
      done = run && (m_q >= win);
      warn = (tec > cfg_warn) || (rec > cfg_warn);
      trip = bus_off || ottr;
      iso  = (m_att == CAP) ? 5 : 3;
      nx = m_state;
      case (m_state)
        0, 1: nx = stk ? 4 : trip ? iso : xcvr_uv ? 2 : warn ? 1 : 0;
        2:    nx = stk ? 4 : trip ? iso : uvok ? (warn ? 1 : 0) : 2;
        3:    nx = done ? 0 : 3;
        4:    nx = idl ? 0 : 4;
        5:    nx = host_clear ? 0 : 5;
        default: nx = 0;
      endcase
      mtx   = (nx == 0) || (nx == 1);
      m_thr = (nx == 1) || (mtx && xcvr_ot);
      m_tx  = mtx && (!m_thr || m_duty == 0);
      m_lo  = (nx == 2); m_sf = (nx == 4); m_lk = (nx == 5);
      m_evt = (nx != m_state);
      if (m_evt) m_etime = m_ts % (1 << TS_W);
      if (bit_tick) begin
        if (!bus_rx) begin m_dom = (m_dom < 511) ? m_dom + 1 : m_dom; m_rec = 0; end
        else begin m_rec = (m_rec < 11) ? m_rec + 1 : m_rec; m_dom = 0; end
      end
      if (xcvr_uv) m_uvc = 0; else if (m_uvc < cfg_uv_hold) m_uvc++;
      if (!xcvr_ot) m_otc = 0; else if (m_otc < OT_LIM) m_otc++;
      if (m_state == 5 && host_clear) m_att = 0;
      else if (m_state == 3 && done && m_att < CAP) m_att++;
      m_q = run ? ((m_q < QM) ? m_q + 1 : m_q) : 0;
      m_duty = (m_duty + 1) % DUTY;
      m_ts++;
      m_state = nx;
    end
  end

  int dwell [8];
  int n_dwell = 0, run_len = 0, prev_code = 0;

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      check(state_code == m_state, "R10 model state_code", state_code, m_state);
      check(tx_en == m_tx, "R2 model tx_en", tx_en, m_tx);
      check(tx_throttle == m_thr, "R8 model tx_throttle", tx_throttle, m_thr);
      check(listen_only == m_lo, "R7 model listen_only", listen_only, m_lo);
      check(stuck_fault == m_sf, "R6 model stuck_fault", stuck_fault, m_sf);
      check(locked_out == m_lk, "R5 model locked_out", locked_out, m_lk);
      check(evt_stb == m_evt, "R9 model evt_stb", evt_stb, m_evt);
      check(evt_time == m_etime, "R9 model evt_time", evt_time, m_etime);
      if (evt_stb) check(state_code != prev_code, "R9 strobe marks a change", state_code, prev_code);
      if (state_code == 3) run_len++;
      else if (run_len != 0) begin
        if (n_dwell < 8) dwell[n_dwell] = run_len;
        n_dwell++;
        run_len = 0;
      end
      prev_code = state_code;
    end
  end

  always @(negedge clk) bit_tick <= ~bit_tick;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_code(input int code, input int lim, input string tag);
    int n = 0;
    while (state_code != code && n < lim) begin @(negedge clk); n++; end
    check(state_code == code, tag, state_code, code);
  endtask

  initial begin
    int txc;
    cyc(4);
    rst = 0;
    check(state_code == 0, "R1 reset code", state_code, 0);
    check(tx_en == 1, "R1 reset tx_en", tx_en, 1);
    check({tx_throttle, listen_only, stuck_fault, locked_out, evt_stb} == 0,
          "R1 reset flags", {tx_throttle, listen_only, stuck_fault, locked_out, evt_stb}, 0);
    cyc(30);

    tec = 96; cyc(3);
    check(state_code == 0, "R2 count equal to threshold", state_code, 0);
    tec = 97; cyc(3);
    check(state_code == 1, "R2 degraded on tec", state_code, 1);
    check(tx_throttle == 1, "R2 throttle", tx_throttle, 1);
    txc = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); txc += tx_en; end
    check(txc == 2, "R2 duty one in four", txc, 2);
    tec = 0; rec = 97; cyc(3);
    check(state_code == 1, "R2 degraded on rec", state_code, 1);
    rec = 0; cyc(3);
    check(state_code == 0, "R2 back to normal", state_code, 0);

    host_clear = 1; cyc(1); host_clear = 0; cyc(2);
    check(state_code == 0 && locked_out == 0, "R5 host_clear ignored when normal", state_code, 0);

    xcvr_uv = 1; cyc(3);
    check(state_code == 2 && listen_only && !tx_en, "R7 listen-only on undervoltage", state_code, 2);
    xcvr_uv = 0; cyc(3);
    check(state_code == 2, "R7 held before rail is stable", state_code, 2);
    cyc(8);
    check(state_code == 0, "R7 released after hold", state_code, 0);

    xcvr_uv = 1; bus_off = 1; cyc(2);
    check(state_code == 3, "R10 bus-off beats undervoltage", state_code, 3);
    check(tx_en == 0, "R3 isolated drops tx", tx_en, 0);
    xcvr_uv = 0;
    wait_code(0, 80, "R4 first rejoin");
    wait_code(3, 10, "R3 re-isolate with bus-off held");
    wait_code(5, 120, "R5 lockout after retry cap");
    check(locked_out == 1, "R5 locked flag", locked_out, 1);
    check(n_dwell >= 2 && dwell[0] >= QB, "R4 first dwell covers base window", dwell[0], QB);
    check(dwell[1] > dwell[0], "R4 backoff lengthens dwell", dwell[1], dwell[0] + 1);
    bus_off = 0; cyc(6);
    check(state_code == 5, "R5 stays locked without host", state_code, 5);
    host_clear = 1; cyc(1); host_clear = 0; cyc(1);
    check(state_code == 0, "R5 host_clear releases", state_code, 0);

    cyc(4);
    bus_off = 1; cyc(1); bus_off = 0; cyc(2);
    check(state_code == 3, "R3 single bus-off pulse", state_code, 3);
    bus_rx = 0; cyc(4); bus_rx = 1;
    wait_code(0, 120, "R4 rejoin after glitch");
    check(dwell[2] > dwell[0] + 15, "R4 glitch restarts window", dwell[2], dwell[0] + 16);

    cyc(4);
    bus_rx = 0; cyc(16);
    check(state_code == 4 && stuck_fault && !tx_en, "R6 stuck dominant", state_code, 4);
    bus_rx = 1; cyc(10);
    check(state_code == 4, "R6 waits for idle", state_code, 4);
    wait_code(0, 40, "R6 recover on idle");

    cyc(4);
    xcvr_ot = 1; cyc(3);
    check(state_code == 0 && tx_throttle, "R8 overtemp throttles", tx_throttle, 1);
    wait_code(3, 40, "R8 overtemp trips isolation");
    xcvr_ot = 0;
    wait_code(0, 80, "R8 rejoin after overtemp");
    cyc(5);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule